// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache that sits between an address generator and memory. It turns a virtual page number into a physical frame number without a second memory access to fetch a page-table entry. Each slot stores a page number, a frame number, an address-space tag and a valid flag. A lookup compares the requested page number and the current address-space tag against every slot at the same time. The result is registered, so it appears one cycle after the request. On a hit, the stored frame is joined to the untranslated page offset to form the physical address. On a miss, a miss flag is raised.

The miss is resolved outside the block. An external walker reads the page table and delivers the frame through the fill port, and the block installs the translation. Because every slot carries an address-space tag, translations that belong to different processes can be held together. Software can discard every translation at once, or only the translations that carry one tag.

Top module: `asid_tlb`

## Requirements
- R1: After a synchronous active-low reset, every slot is empty and `rsp_valid` is low, so the first lookup after reset reports a miss.
- R2: Each cycle with `lkp_valid` high produces exactly one cycle of `rsp_valid` in the following cycle. In that cycle exactly one of `rsp_hit` and `rsp_miss` is high. Both flags are low whenever `rsp_valid` is low.
- R3: A lookup hits only when a valid slot holds both the requested page number and a tag equal to `cur_asid`. A matching page number under a different tag is a miss.
- R4: `rsp_paddr` is 30 bits wide. Bits 9:0 always carry the requested offset. Bits 29:10 carry the stored frame on a hit and zero on a miss.
- R5: A fill that matches no existing translation goes to the lowest-numbered empty slot.
- R6: When no slot is empty, a fill replaces the slot selected by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only on such a replacement.
- R7: A fill whose page number and tag are already present overwrites the frame in that same slot. It takes no new slot and does not move the round-robin pointer.
- R8: `flush_all` empties every slot. A fill presented in the same cycle is dropped.
- R9: `flush_asid_en` empties only the slots whose tag equals `flush_asid`. Slots with other tags keep hitting. A fill presented in the same cycle is still installed.
- R10: A lookup made in the same cycle as the fill of the same page reports a miss. The new translation hits from the next cycle on.
- R11: A lookup made in the same cycle as a flush sees the contents from before the flush.
- R12: At most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | 22 | Virtual page number to translate |
| lkp_off | input | 10 | Page offset, passed through |
| cur_asid | input | 8 | Address-space tag of the requesting process |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation absent |
| rsp_paddr | output | 30 | Physical address {frame, offset} |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 22 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_asid | input | 8 | Tag of the installed translation |
| flush_all | input | 1 | Empty every slot |
| flush_asid_en | input | 1 | Empty slots carrying `flush_asid` |
| flush_asid | input | 8 | Tag selected for flushing |

## Verification
The replacement order is the hardest behaviour to observe, because slot numbers never reach the ports. The stimulus fills the table with pages under two tags and flushes one tag, which opens alternate holes. It then refills those holes and forces evictions. Each eviction is identified by which earlier page stops hitting. That page reveals whether the holes were filled lowest-first, whether the pointer started at slot 0, and whether an in-place refresh left the pointer where it was. A flush-by-tag combined with a same-cycle fill into a full table checks that the fill survives the flush.

// File: rtl/asid_tlb_pkg.sv
// Package: shared defaults and the fill-slot classification used by the
// translation buffer. Assumes nothing beyond IEEE 1800-2017.
package asid_tlb_pkg;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_VPN_W   = 22;
    localparam int unsigned DEF_OFF_W   = 10;
    localparam int unsigned DEF_PFN_W   = 20;
    localparam int unsigned DEF_ASID_W  = 8;

    // How a fill chooses its slot.
    typedef enum logic [1:0] {
        SLOT_REFRESH = 2'd0,   // same page and tag already present
        SLOT_FREE    = 2'd1,   // lowest empty slot
        SLOT_EVICT   = 2'd2    // round-robin victim
    } slot_kind_e;
endpackage

// File: rtl/tlb_match.sv
// tlb_match: parallel comparison of one key against all slots.
// Produces one match bit per slot. Assumes the caller keeps entries unique
// per (page, tag), so the result is one-hot or zero.
module tlb_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 22,
    parameter int unsigned ASID_W  = 8
) (
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [VPN_W-1:0]   vpn_arr  [ENTRIES],
    input  logic [ASID_W-1:0]  asid_arr [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [ASID_W-1:0]  key_asid,
    output logic [ENTRIES-1:0] hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // Per-slot comparator: valid, page and tag must all agree.
        always_comb begin
            hit_vec[g] = valid_vec[g]
                       && (vpn_arr[g] == key_vpn)
                       && (asid_arr[g] == key_asid);
        end
    end
endmodule

// File: rtl/tlb_entry_store.sv
// tlb_entry_store: slot storage with write and flush.
// Per cycle: flush_all wins over everything. Otherwise a write to a slot
// wins over the tag flush of that slot, and other slots with a matching
// tag are emptied.
module tlb_entry_store #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 22,
    parameter int unsigned PFN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               flush_all,
    input  logic               flush_asid_en,
    input  logic [ASID_W-1:0]  flush_asid,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [VPN_W-1:0]   vpn_arr  [ENTRIES],
    output logic [PFN_W-1:0]   pfn_arr  [ENTRIES],
    output logic [ASID_W-1:0]  asid_arr [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;

        // Decode whether this slot is the write target.
        always_comb sel = wr_en && (wr_idx == IDX_W'(g));

        // Valid flag: reset, flush-all, write, tag flush in that order.
        always_ff @(posedge clk) begin
            if (!rst_n)                                         valid_vec[g] <= 1'b0;
            else if (flush_all)                                 valid_vec[g] <= 1'b0;
            else if (sel)                                       valid_vec[g] <= 1'b1;
            else if (flush_asid_en && asid_arr[g] == flush_asid) valid_vec[g] <= 1'b0;
        end

        // Payload fields: loaded on a write that is not cancelled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_arr[g]  <= '0;
                pfn_arr[g]  <= '0;
                asid_arr[g] <= '0;
            end else if (sel && !flush_all) begin
                vpn_arr[g]  <= wr_vpn;
                pfn_arr[g]  <= wr_pfn;
                asid_arr[g] <= wr_asid;
            end
        end
    end
endmodule

// File: rtl/tlb_slot_select.sv
// tlb_slot_select: picks the slot a fill writes. The order of preference is
// the existing matching slot, then the lowest empty slot, then the
// round-robin victim. Holds the victim pointer, which moves only on an
// accepted eviction. Assumes dup_vec is one-hot or zero.
module tlb_slot_select
    import asid_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    input  logic               fill_go,
    output logic [IDX_W-1:0]   slot_idx,
    output slot_kind_e         slot_kind
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Encode the one-hot duplicate vector into an index.
    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (dup_vec[i]) dup_idx = dup_idx | IDX_W'(i);
    end

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    // Choose slot and classify the fill.
    always_comb begin
        if (|dup_vec) begin
            slot_kind = SLOT_REFRESH;
            slot_idx  = dup_idx;
        end else if (free_any) begin
            slot_kind = SLOT_FREE;
            slot_idx  = free_idx;
        end else begin
            slot_kind = SLOT_EVICT;
            slot_idx  = rr_ptr;
        end
    end

    // Victim pointer: advance with wrap after each accepted eviction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (fill_go && slot_kind == SLOT_EVICT)
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end
endmodule

// File: rtl/asid_tlb.sv
// asid_tlb: fully associative, tag-qualified translation buffer with a
// registered lookup response, walker fill port and two flush modes.
// Assumes a single clock and a synchronous active-low reset. A lookup sees
// the slot contents from before any same-cycle fill or flush.
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned OFF_W   = DEF_OFF_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned ASID_W  = DEF_ASID_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lkp_valid,
    input  logic [VPN_W-1:0]       lkp_vpn,
    input  logic [OFF_W-1:0]       lkp_off,
    input  logic [ASID_W-1:0]      cur_asid,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_miss,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PFN_W-1:0]       fill_pfn,
    input  logic [ASID_W-1:0]      fill_asid,
    input  logic                   flush_all,
    input  logic                   flush_asid_en,
    input  logic [ASID_W-1:0]      flush_asid
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned PA_W  = PFN_W + OFF_W;

    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PFN_W-1:0]   pfn_q  [ENTRIES];
    logic [ASID_W-1:0]  asid_q [ENTRIES];

    logic [ENTRIES-1:0] lkp_hit_vec;
    logic [ENTRIES-1:0] fill_dup_vec;
    logic               lkp_hit_any;
    logic [PFN_W-1:0]   lkp_pfn;
    logic               fill_go;
    logic [IDX_W-1:0]   fill_idx;
    slot_kind_e         fill_kind;

    // Lookup-side comparator bank.
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_match (
        .valid_vec (valid_q),
        .vpn_arr   (vpn_q),
        .asid_arr  (asid_q),
        .key_vpn   (lkp_vpn),
        .key_asid  (cur_asid),
        .hit_vec   (lkp_hit_vec)
    );

    // Fill-side comparator bank that finds an existing copy.
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
        .valid_vec (valid_q),
        .vpn_arr   (vpn_q),
        .asid_arr  (asid_q),
        .key_vpn   (fill_vpn),
        .key_asid  (fill_asid),
        .hit_vec   (fill_dup_vec)
    );

    // A fill is accepted unless a full flush cancels it.
    always_comb fill_go = fill_valid && !flush_all;

    tlb_slot_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_q),
        .dup_vec   (fill_dup_vec),
        .fill_go   (fill_go),
        .slot_idx  (fill_idx),
        .slot_kind (fill_kind)
    );

    tlb_entry_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
        .ASID_W(ASID_W), .IDX_W(IDX_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (fill_go),
        .wr_idx        (fill_idx),
        .wr_vpn        (fill_vpn),
        .wr_pfn        (fill_pfn),
        .wr_asid       (fill_asid),
        .flush_all     (flush_all),
        .flush_asid_en (flush_asid_en),
        .flush_asid    (flush_asid),
        .valid_vec     (valid_q),
        .vpn_arr       (vpn_q),
        .pfn_arr       (pfn_q),
        .asid_arr      (asid_q)
    );

    // AND-OR select of the matching frame (match vector is one-hot or zero).
    always_comb begin
        lkp_pfn = '0;
        for (int i = 0; i < ENTRIES; i++)
            lkp_pfn = lkp_pfn | (pfn_q[i] & {PFN_W{lkp_hit_vec[i]}});
        lkp_hit_any = |lkp_hit_vec;
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= lkp_valid;
            rsp_hit   <= lkp_valid && lkp_hit_any;
            rsp_miss  <= lkp_valid && !lkp_hit_any;
            rsp_paddr <= lkp_valid ? PA_W'({lkp_pfn, lkp_off}) : '0;
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
// asid_tlb_chk: property checker bound to asid_tlb. It watches the ports and
// the slot valid and match vectors. A one-cycle history flag keeps every
// $past() inside the cycles since reset.
module asid_tlb_chk #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned OFF_W   = 10,
    parameter int unsigned PFN_W   = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lkp_valid,
    input logic [OFF_W-1:0]       lkp_off,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic                   rsp_miss,
    input logic [PFN_W+OFF_W-1:0] rsp_paddr,
    input logic                   flush_all,
    input logic [ENTRIES-1:0]     valid_q,
    input logic [ENTRIES-1:0]     lkp_hit_vec,
    input logic [ENTRIES-1:0]     fill_dup_vec
);
    logic seen_q;

    // History flag: set one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (rsp_valid == $past(lkp_valid)));

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));

    a_r2_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && rsp_valid) |-> (rsp_paddr[OFF_W-1:0] == $past(lkp_off)));

    a_r4_miss_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr[PFN_W+OFF_W-1:OFF_W] == '0));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(flush_all)) |-> (valid_q == '0));

    a_r12_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lkp_hit_vec));

    a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_dup_vec));
endmodule

bind asid_tlb asid_tlb_chk #(
    .ENTRIES (ENTRIES),
    .OFF_W   (OFF_W),
    .PFN_W   (PFN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lkp_valid    (lkp_valid),
    .lkp_off      (lkp_off),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_paddr    (rsp_paddr),
    .flush_all    (flush_all),
    .valid_q      (valid_q),
    .lkp_hit_vec  (lkp_hit_vec),
    .fill_dup_vec (fill_dup_vec)
);

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
// sim_asid_tlb: self-checking bench. A vector table is walked first, then
// directed tests for flushes, same-cycle interactions and replacement order.
module sim_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [21:0] lkp_vpn = '0;
    logic [9:0]  lkp_off = '0;
    logic [7:0]  cur_asid = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [29:0] rsp_paddr;
    logic        fill_valid = 1'b0;
    logic [21:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [7:0]  fill_asid = '0;
    logic        flush_all = 1'b0;
    logic        flush_asid_en = 1'b0;
    logic [7:0]  flush_asid = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    asid_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_off(lkp_off), .cur_asid(cur_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_asid(fill_asid),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    typedef struct packed {
        logic        is_fill;
        logic [21:0] vpn;
        logic [7:0]  asid;
        logic [19:0] pfn;
        logic [9:0]  off;
        logic        exp_hit;
    } vec_t;

    // Fills and lookups; lookups check R3 (tag match) and R4 (address form).
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 22'h100, 8'h01, 20'hA0001, 10'h000, 1'b0},
        '{1'b1, 22'h101, 8'h01, 20'hA0002, 10'h000, 1'b0},
        '{1'b1, 22'h100, 8'h02, 20'hB0001, 10'h000, 1'b0},
        '{1'b0, 22'h100, 8'h01, 20'hA0001, 10'h155, 1'b1},
        '{1'b0, 22'h100, 8'h02, 20'hB0001, 10'h2AA, 1'b1},
        '{1'b0, 22'h100, 8'h03, 20'h00000, 10'h3FF, 1'b0},
        '{1'b0, 22'h102, 8'h01, 20'h00000, 10'h001, 1'b0},
        '{1'b0, 22'h101, 8'h01, 20'hA0002, 10'h0F0, 1'b1},
        '{1'b1, 22'h101, 8'h01, 20'hC0003, 10'h000, 1'b0},
        '{1'b0, 22'h101, 8'h01, 20'hC0003, 10'h00F, 1'b1}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Check a response already sampled after the edge that registered it.
    task automatic check_rsp(input bit exp_hit, input logic [19:0] exp_pfn,
                             input logic [9:0] off, input string tag);
        logic [29:0] exp_pa;
        exp_pa = exp_hit ? {exp_pfn, off} : {20'h0, off};
        check(rsp_valid == 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_hit == exp_hit && rsp_miss == !exp_hit, {tag, " hit/miss"},
              64'({rsp_hit, rsp_miss}), 64'({exp_hit, !exp_hit}));
        check(rsp_paddr == exp_pa, {tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
    endtask

    task automatic lookup(input logic [21:0] vpn, input logic [7:0] asid,
                          input logic [9:0] off, input bit exp_hit,
                          input logic [19:0] exp_pfn, input string tag);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_vpn = vpn; cur_asid = asid; lkp_off = off;
        @(negedge clk);
        lkp_valid = 1'b0;
        check_rsp(exp_hit, exp_pfn, off, tag);
    endtask

    task automatic fill(input logic [21:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        lookup(22'h005, 8'h01, 10'h012, 1'b0, 20'h0, "R1 empty lookup");
        @(negedge clk);
        check(!rsp_valid && !rsp_hit && !rsp_miss, "R2 idle flags",
              64'({rsp_valid, rsp_hit, rsp_miss}), 64'd0);

        // Vector table: R3, R4, R7 refresh
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_fill)
                fill(VECS[i].vpn, VECS[i].asid, VECS[i].pfn);
            else
                lookup(VECS[i].vpn, VECS[i].asid, VECS[i].off, VECS[i].exp_hit,
                       VECS[i].pfn, $sformatf("R3/R4 vector %0d", i));
        end

        // R8 + R11: flush-all with same-cycle fill and lookup
        @(negedge clk);
        flush_all = 1'b1;
        fill_valid = 1'b1; fill_vpn = 22'h200; fill_asid = 8'h01; fill_pfn = 20'h22222;
        lkp_valid = 1'b1; lkp_vpn = 22'h100; cur_asid = 8'h01; lkp_off = 10'h3C3;
        @(negedge clk);
        flush_all = 1'b0; fill_valid = 1'b0; lkp_valid = 1'b0;
        check_rsp(1'b1, 20'hA0001, 10'h3C3, "R11 lookup during flush");
        lookup(22'h100, 8'h01, 10'h004, 1'b0, 20'h0, "R8 flushed page");
        lookup(22'h100, 8'h02, 10'h005, 1'b0, 20'h0, "R8 flushed other tag");
        lookup(22'h200, 8'h01, 10'h006, 1'b0, 20'h0, "R8 dropped fill");

        // R10: fill and lookup of same page in one cycle
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 22'h300; fill_asid = 8'h01; fill_pfn = 20'h33333;
        lkp_valid = 1'b1; lkp_vpn = 22'h300; cur_asid = 8'h01; lkp_off = 10'h077;
        @(negedge clk);
        fill_valid = 1'b0; lkp_valid = 1'b0;
        check_rsp(1'b0, 20'h0, 10'h077, "R10 same-cycle miss");
        lookup(22'h300, 8'h01, 10'h078, 1'b1, 20'h33333, "R10 next-cycle hit");

        // Fill slots 1..7: odd under tag 2, even under tag 1
        for (int i = 1; i < 8; i++)
            fill(22'h400 + 22'(i), (i % 2 == 1) ? 8'h02 : 8'h01, 20'h40000 + 20'(i));

        // R9: flush tag 2 only
        @(negedge clk);
        flush_asid_en = 1'b1; flush_asid = 8'h02;
        @(negedge clk);
        flush_asid_en = 1'b0;
        lookup(22'h401, 8'h02, 10'h001, 1'b0, 20'h0, "R9 flushed tag");
        lookup(22'h402, 8'h01, 10'h002, 1'b1, 20'h40002, "R9 other tag kept");
        lookup(22'h300, 8'h01, 10'h003, 1'b1, 20'h33333, "R9 slot0 kept");

        // R5: refill holes 1,3,5,7 lowest first
        for (int i = 0; i < 4; i++)
            fill(22'h600 + 22'(i), 8'h03, 20'h60000 + 20'(i));

        // R6: first eviction hits slot 0, second hits slot 1
        fill(22'h700, 8'h03, 20'h70000);
        lookup(22'h300, 8'h01, 10'h010, 1'b0, 20'h0, "R6 slot0 evicted");
        lookup(22'h600, 8'h03, 10'h011, 1'b1, 20'h60000, "R6 slot1 kept");
        fill(22'h701, 8'h03, 20'h70001);
        lookup(22'h600, 8'h03, 10'h012, 1'b0, 20'h0, "R5/R6 slot1 evicted");
        lookup(22'h601, 8'h03, 10'h013, 1'b1, 20'h60001, "R5 slot3 kept");
        lookup(22'h700, 8'h03, 10'h014, 1'b1, 20'h70000, "R6 new entry");

        // R7: refresh in place does not move the pointer (next victim slot 2)
        fill(22'h402, 8'h01, 20'h12345);
        lookup(22'h402, 8'h01, 10'h020, 1'b1, 20'h12345, "R7 refreshed frame");
        fill(22'h702, 8'h03, 20'h70002);
        lookup(22'h402, 8'h01, 10'h021, 1'b0, 20'h0, "R7 slot2 evicted");
        lookup(22'h601, 8'h03, 10'h022, 1'b1, 20'h60001, "R7 slot3 kept");

        // R9: tag flush with same-cycle fill into full table (victim slot 3)
        @(negedge clk);
        flush_asid_en = 1'b1; flush_asid = 8'h03;
        fill_valid = 1'b1; fill_vpn = 22'h800; fill_asid = 8'h03; fill_pfn = 20'h88888;
        @(negedge clk);
        flush_asid_en = 1'b0; fill_valid = 1'b0;
        lookup(22'h800, 8'h03, 10'h030, 1'b1, 20'h88888, "R9 fill survives flush");
        lookup(22'h700, 8'h03, 10'h031, 1'b0, 20'h0, "R9 tag cleared");
        lookup(22'h404, 8'h01, 10'h032, 1'b1, 20'h40004, "R9 tag 1 kept");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule